// File: doc/BRIEF.md
# Expansion Card Configuration and Select Logic

This block sits on the host bus side of a plug-in expansion card that carries RAM, a boot ROM and a disk controller. It answers the host while the card is being configured and, once the host has placed the card, decodes host addresses into chip selects for the card's RAM and boot ROM. It also drives the slave/override line and the bus acknowledge for the cycles that the card answers by itself.

The amount of RAM fitted is set by a single jumper-driven strap pin. The pin can be tied low, tied high, driven by a reference clock or driven by the inverse of that clock. A level read cannot tell these four states apart. The block therefore samples the strap on every phase of the reference clock over a window, classifies it, and reports the result as a size code in a configuration status register. The host reads that register, then writes a 64 KB block base address. After that write the boot ROM answers in the block at the base, and the RAM answers in the blocks that follow it.

All bus outputs are registered. The reference clock and strap inputs must be synchronous to `clk`, or synchronised before they reach the block. The reference clock must run slower than half the `clk` rate.

Top module: `acfg_expansion_select`

## Requirements
- R1: A strap held at 0 for a whole classification window reports size code 0 (no RAM) with the valid bit set. The status register is read at configuration offset 0x0000: bits [1:0] hold the size code, bit 2 the valid flag, bit 3 the configured flag, and the other bits read 0.
- R2: A strap that is always the opposite of the reference clock on every sampled phase reports size code 1 (512 KB, 8 blocks of 64 KB).
- R3: A strap that equals the reference clock on every sampled phase reports size code 2 (1 MB, 16 blocks).
- R4: A strap held at 1 for a whole window reports size code 3 (2 MB, 32 blocks).
- R5: A strap that fits none of the four patterns within a window reports size code 0 with the valid bit clear.
- R6: `slave_n_o` goes low one clock after a strobe (`bus_as_n_i` low) is sampled with address bits [23:16] equal to the configuration block 0xE8. It goes high one clock after the strobe is released.
- R7: `dtack_n_o` goes low one clock after `slave_n_o` or `rom_cs_n_o` has gone low, and it goes high one clock after the strobe ends. RAM cycles never raise it.
- R8: Until a base address has been written, `ram_sel_n_o` and `rom_cs_n_o` stay high for every address. Only the configuration block responds.
- R9: A write strobe (`bus_rw_i` low) to configuration offset 0x0048 stores `bus_wdata_i` as the base block and sets the configured flag. The base block reads back at offset 0x0002. Configuration read data appears one clock after the read strobe is sampled and is 0 outside configuration reads.
- R10: Once configured, `rom_cs_n_o` selects the block equal to the base. `ram_sel_n_o` selects blocks base+1 through base+N, where N is 8, 16 or 32 for size codes 1, 2 and 3. Every other block gets neither select.
- R11: Reset clears the configured flag and the base register and drives every active-low output high and the read data to 0.
- R12: The base register is written only once per strobe, at its start. Write data that changes while the strobe is held has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_clk_i | input | 1 | Reference clock, sampled as data |
| size_strap_i | input | 1 | Jumper-driven RAM size strap |
| bus_as_n_i | input | 1 | Host address strobe, active low |
| bus_rw_i | input | 1 | 1 = read, 0 = write |
| bus_addr_i | input | 24 | Host byte address |
| bus_wdata_i | input | 8 | Host write data for the base register |
| cfg_rdata_o | output | 8 | Configuration read data |
| ram_sel_n_o | output | 1 | RAM select, active low |
| rom_cs_n_o | output | 1 | Boot ROM chip select, active low |
| slave_n_o | output | 1 | Slave/override, active low |
| dtack_n_o | output | 1 | Bus acknowledge for configuration and ROM cycles, active low |

## Verification
The selects and the read data are due one clock after the edge that first samples a strobe. The acknowledge is due one clock later than the select. Every output is due back at its idle level one clock after the strobe rises. The size code settles within two classification windows of a strap change, so the bench waits well past that before it reads status. The driver pushes each expectation with the cycle number in which it is due, and the monitor compares only at the falling edge of that cycle, after every register has settled.

// File: rtl/acfg_pkg.sv
package acfg_pkg;

  typedef enum logic [1:0] {
    SZ_NONE = 2'd0,
    SZ_512K = 2'd1,
    SZ_1M   = 2'd2,
    SZ_2M   = 2'd3
  } ram_size_e;

  // RAM extent in 64 KB blocks for each size code
  function automatic logic [5:0] size_blocks(ram_size_e s);
    case (s)
      SZ_512K: size_blocks = 6'd8;
      SZ_1M:   size_blocks = 6'd16;
      SZ_2M:   size_blocks = 6'd32;
      default: size_blocks = 6'd0;
    endcase
  endfunction

endpackage

// File: rtl/acfg_strap_classifier.sv
module acfg_strap_classifier
  import acfg_pkg::*;
#(
  parameter int PHASES = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ref_i,
  input  logic      strap_i,
  output ram_size_e size_o,
  output logic      valid_o
);

  localparam int CNT_W = (PHASES > 2) ? $clog2(PHASES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PHASES - 1);

  logic             ref_q, ref_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hi_q, hi_d, lo_q, lo_d, eq_q, eq_d, ne_q, ne_d;
  ram_size_e        size_q, size_d;
  logic             valid_q, valid_d;

  logic phase_edge;
  logic hi_n, lo_n, eq_n, ne_n;

  assign phase_edge = ref_i ^ ref_q;

  always_comb begin
    ref_d   = ref_i;
    cnt_d   = cnt_q;
    hi_d    = hi_q;
    lo_d    = lo_q;
    eq_d    = eq_q;
    ne_d    = ne_q;
    size_d  = size_q;
    valid_d = valid_q;
    // evidence including the sample taken on this phase
    hi_n    = hi_q | strap_i;
    lo_n    = lo_q | ~strap_i;
    eq_n    = eq_q | (strap_i == ref_i);
    ne_n    = ne_q | (strap_i != ref_i);
    if (phase_edge) begin
      if (cnt_q == LAST) begin
        cnt_d   = '0;
        hi_d    = 1'b0;
        lo_d    = 1'b0;
        eq_d    = 1'b0;
        ne_d    = 1'b0;
        valid_d = 1'b1;
        if (!hi_n)      size_d = SZ_NONE;
        else if (!lo_n) size_d = SZ_2M;
        else if (!ne_n) size_d = SZ_1M;
        else if (!eq_n) size_d = SZ_512K;
        else begin
          size_d  = SZ_NONE;
          valid_d = 1'b0;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
        hi_d  = hi_n;
        lo_d  = lo_n;
        eq_d  = eq_n;
        ne_d  = ne_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q   <= 1'b0;
      cnt_q   <= '0;
      hi_q    <= 1'b0;
      lo_q    <= 1'b0;
      eq_q    <= 1'b0;
      ne_q    <= 1'b0;
      size_q  <= SZ_NONE;
      valid_q <= 1'b0;
    end else begin
      ref_q <= ref_d;
      if (phase_edge) begin
        cnt_q   <= cnt_d;
        hi_q    <= hi_d;
        lo_q    <= lo_d;
        eq_q    <= eq_d;
        ne_q    <= ne_d;
        size_q  <= size_d;
        valid_q <= valid_d;
      end
    end
  end

  assign size_o  = size_q;
  assign valid_o = valid_q;

endmodule

// File: rtl/acfg_cfg_regs.sv
module acfg_cfg_regs
  import acfg_pkg::*;
#(
  parameter int                 BLK_W    = 8,
  parameter int                 OFS_W    = 16,
  parameter logic [OFS_W-1:0]   OFS_STAT = 16'h0000,
  parameter logic [OFS_W-1:0]   OFS_BASE = 16'h0002
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [BLK_W-1:0] wdata,
  input  logic [OFS_W-1:0] rd_ofs,
  input  ram_size_e        size,
  input  logic             size_valid,
  output logic [BLK_W-1:0] base_o,
  output logic             configured_o,
  output logic [BLK_W-1:0] rd_word
);

  logic [BLK_W-1:0] base_q, base_d;
  logic             cfg_q, cfg_d;

  always_comb begin
    base_d = base_q;
    cfg_d  = cfg_q;
    if (wr_stb) begin
      base_d = wdata;
      cfg_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cfg_q  <= 1'b0;
    end else if (wr_stb) begin
      base_q <= base_d;
      cfg_q  <= cfg_d;
    end
  end

  always_comb begin
    if (rd_ofs == OFS_STAT)
      rd_word = {{(BLK_W-4){1'b0}}, cfg_q, size_valid, size};
    else if (rd_ofs == OFS_BASE)
      rd_word = base_q;
    else
      rd_word = '0;
  end

  assign base_o       = base_q;
  assign configured_o = cfg_q;

endmodule

// File: rtl/acfg_decode.sv
module acfg_decode
  import acfg_pkg::*;
#(
  parameter int               ADDR_W  = 24,
  parameter int               BLK_W   = 8,
  parameter logic [BLK_W-1:0] CFG_BLK = 8'hE8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BLK_W-1:0]  base,
  input  logic              configured,
  input  ram_size_e         size,
  output logic              cfg_hit,
  output logic              rom_hit,
  output logic              ram_hit
);

  logic [BLK_W-1:0] blk, rel, nblk;

  assign blk  = addr[ADDR_W-1 -: BLK_W];
  assign rel  = blk - base;
  assign nblk = {{(BLK_W-6){1'b0}}, size_blocks(size)};

  always_comb begin
    cfg_hit = (blk == CFG_BLK);
    rom_hit = configured && !cfg_hit && (rel == '0);
    ram_hit = configured && !cfg_hit && (rel != '0) && (rel <= nblk);
  end

endmodule

// File: rtl/acfg_expansion_select.sv
module acfg_expansion_select
  import acfg_pkg::*;
#(
  parameter int                 ADDR_W        = 24,
  parameter int                 BLK_W         = 8,
  parameter logic [BLK_W-1:0]   CFG_BLK       = 8'hE8,
  parameter int                 STRAP_PERIODS = 4,
  parameter int                 OFS_W         = ADDR_W - BLK_W,
  parameter logic [OFS_W-1:0]   OFS_STAT      = 16'h0000,
  parameter logic [OFS_W-1:0]   OFS_BASE_RD   = 16'h0002,
  parameter logic [OFS_W-1:0]   OFS_BASE_WR   = 16'h0048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_clk_i,
  input  logic              size_strap_i,
  input  logic              bus_as_n_i,
  input  logic              bus_rw_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BLK_W-1:0]  bus_wdata_i,
  output logic [BLK_W-1:0]  cfg_rdata_o,
  output logic              ram_sel_n_o,
  output logic              rom_cs_n_o,
  output logic              slave_n_o,
  output logic              dtack_n_o
);

  localparam int PHASES = 2 * STRAP_PERIODS;

  logic [1:0] rst_pipe;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  ram_size_e        size;
  logic             size_valid;
  logic [BLK_W-1:0] base;
  logic             configured;
  logic [BLK_W-1:0] rd_word;
  logic             cfg_hit, rom_hit, ram_hit;
  logic             as_q;
  logic             strobe, strobe_start, wr_stb;

  acfg_strap_classifier #(.PHASES(PHASES)) u_strap (
    .clk     (clk),
    .rst_n   (rst_ns),
    .ref_i   (ref_clk_i),
    .strap_i (size_strap_i),
    .size_o  (size),
    .valid_o (size_valid)
  );

  acfg_decode #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .CFG_BLK(CFG_BLK)) u_dec (
    .addr       (bus_addr_i),
    .base       (base),
    .configured (configured),
    .size       (size),
    .cfg_hit    (cfg_hit),
    .rom_hit    (rom_hit),
    .ram_hit    (ram_hit)
  );

  assign strobe       = !bus_as_n_i;
  assign strobe_start = strobe && as_q;
  assign wr_stb       = strobe_start && !bus_rw_i && cfg_hit &&
                        (bus_addr_i[OFS_W-1:0] == OFS_BASE_WR);

  acfg_cfg_regs #(
    .BLK_W(BLK_W), .OFS_W(OFS_W), .OFS_STAT(OFS_STAT), .OFS_BASE(OFS_BASE_RD)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_ns),
    .wr_stb       (wr_stb),
    .wdata        (bus_wdata_i),
    .rd_ofs       (bus_addr_i[OFS_W-1:0]),
    .size         (size),
    .size_valid   (size_valid),
    .base_o       (base),
    .configured_o (configured),
    .rd_word      (rd_word)
  );

  logic             slave_d, rom_d, ram_d, dtack_d;
  logic [BLK_W-1:0] rdata_d;

  always_comb begin
    slave_d = !(strobe && cfg_hit);
    rom_d   = !(strobe && rom_hit);
    ram_d   = !(strobe && ram_hit);
    dtack_d = !(strobe && ((cfg_hit && !slave_n_o) || (rom_hit && !rom_cs_n_o)));
    rdata_d = (strobe && bus_rw_i && cfg_hit) ? rd_word : '0;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      as_q        <= 1'b1;
      slave_n_o   <= 1'b1;
      rom_cs_n_o  <= 1'b1;
      ram_sel_n_o <= 1'b1;
      dtack_n_o   <= 1'b1;
      cfg_rdata_o <= '0;
    end else begin
      as_q        <= bus_as_n_i;
      slave_n_o   <= slave_d;
      rom_cs_n_o  <= rom_d;
      ram_sel_n_o <= ram_d;
      dtack_n_o   <= dtack_d;
      cfg_rdata_o <= rdata_d;
    end
  end

endmodule

// File: rtl/acfg_sva.sv
module acfg_sva #(
  parameter int BLK_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             as_n,
  input logic             rw,
  input logic             configured,
  input logic             slave_n,
  input logic             rom_cs_n,
  input logic             ram_sel_n,
  input logic             dtack_n,
  input logic [BLK_W-1:0] rdata
);

  a_r6_slave_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !slave_n |-> $past(!as_n));

  a_r7_ack_follows_select: assert property (@(posedge clk) disable iff (!rst_n)
    !dtack_n |-> $past(!slave_n || !rom_cs_n));

  a_r7_no_ack_on_ram: assert property (@(posedge clk) disable iff (!rst_n)
    !dtack_n |-> ram_sel_n);

  a_r10_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!ram_sel_n, !rom_cs_n, !slave_n}));

  a_r8_quiet_until_placed: assert property (@(posedge clk) disable iff (!rst_n)
    !configured |=> (ram_sel_n && rom_cs_n));

  a_r9_rdata_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata != '0) |-> $past(!as_n && rw));

endmodule

bind acfg_expansion_select acfg_sva #(.BLK_W(BLK_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_ns),
  .as_n       (bus_as_n_i),
  .rw         (bus_rw_i),
  .configured (configured),
  .slave_n    (slave_n_o),
  .rom_cs_n   (rom_cs_n_o),
  .ram_sel_n  (ram_sel_n_o),
  .dtack_n    (dtack_n_o),
  .rdata      (cfg_rdata_o)
);

// File: tb/acfg_expansion_select_tb.sv
module acfg_expansion_select_tb;

  localparam int F_SLAVE = 0, F_ROM = 1, F_RAM = 2, F_ACK = 3, F_RDATA = 4;
  localparam int S_NONE = 0, S_SLAVE = 1, S_ROM = 2, S_RAM = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ref_clk = 1'b0;
  logic        strap;
  logic        as_n, rw;
  logic [23:0] addr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic        ram_sel_n, rom_cs_n, slave_n, dtack_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int mode = 0;
  int ref_div = 0;
  logic half = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (ref_div == 3) begin
      ref_div <= 0;
      ref_clk <= ~ref_clk;
      if (ref_clk) half <= ~half;
    end else begin
      ref_div <= ref_div + 1;
    end
  end

  always_comb begin
    case (mode)
      0:       strap = 1'b0;
      1:       strap = 1'b1;
      2:       strap = ref_clk;
      3:       strap = ~ref_clk;
      default: strap = half;
    endcase
  end

  acfg_expansion_select u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_clk_i    (ref_clk),
    .size_strap_i (strap),
    .bus_as_n_i   (as_n),
    .bus_rw_i     (rw),
    .bus_addr_i   (addr),
    .bus_wdata_i  (wdata),
    .cfg_rdata_o  (rdata),
    .ram_sel_n_o  (ram_sel_n),
    .rom_cs_n_o   (rom_cs_n),
    .slave_n_o    (slave_n),
    .dtack_n_o    (dtack_n)
  );

  typedef struct {
    int    due;
    int    field;
    int    val;
    string tag;
  } exp_t;
  exp_t sbq[$];

  function automatic int probe(int f);
    case (f)
      F_SLAVE: return int'(slave_n);
      F_ROM:   return int'(rom_cs_n);
      F_RAM:   return int'(ram_sel_n);
      F_ACK:   return int'(dtack_n);
      default: return int'(rdata);
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic push(int lat, int field, int val, string tag);
    exp_t e;
    e.due = cyc + lat; e.field = field; e.val = val; e.tag = tag;
    sbq.push_back(e);
  endtask

  // monitor: compares every expectation in the cycle it is due
  always @(negedge clk) begin
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].due == cyc) begin
        check(sbq[i].tag, probe(sbq[i].field), sbq[i].val);
        sbq.delete(i);
      end
    end
  end

  task automatic bus_cycle(logic [23:0] a, logic r, logic [7:0] wd, logic [7:0] wd2,
                           int sel, int rd, string tag);
    int ack;
    ack = (sel == S_SLAVE || sel == S_ROM) ? 0 : 1;
    @(negedge clk);
    as_n = 1'b0; addr = a; rw = r; wdata = wd;
    push(1, F_SLAVE, (sel == S_SLAVE) ? 0 : 1, tag);
    push(1, F_ROM,   (sel == S_ROM)   ? 0 : 1, tag);
    push(1, F_RAM,   (sel == S_RAM)   ? 0 : 1, tag);
    push(1, F_ACK,   1, tag);
    if (rd >= 0) push(1, F_RDATA, rd, tag);
    push(2, F_ACK, ack, tag);
    push(2, F_SLAVE, (sel == S_SLAVE) ? 0 : 1, tag);
    push(2, F_ROM,   (sel == S_ROM)   ? 0 : 1, tag);
    push(2, F_RAM,   (sel == S_RAM)   ? 0 : 1, tag);
    @(negedge clk);
    wdata = wd2;
    @(negedge clk);
    as_n = 1'b1; rw = 1'b1;
    push(1, F_SLAVE, 1, {tag, " release"});
    push(1, F_ROM,   1, {tag, " release"});
    push(1, F_RAM,   1, {tag, " release"});
    push(1, F_ACK,   1, {tag, " release"});
    push(1, F_RDATA, 0, {tag, " release"});
  endtask

  task automatic read_cfg(logic [15:0] ofs, int exp, string tag);
    bus_cycle({8'hE8, ofs}, 1'b1, 8'h00, 8'h00, S_SLAVE, exp, tag);
  endtask

  task automatic set_mode(int m);
    @(negedge clk);
    mode = m;
    repeat (100) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    as_n = 1'b1; rw = 1'b1; addr = '0; wdata = '0;
    #1;
    check("R11 reset slave_n", int'(slave_n), 1);
    check("R11 reset rom_cs_n", int'(rom_cs_n), 1);
    check("R11 reset ram_sel_n", int'(ram_sel_n), 1);
    check("R11 reset dtack_n", int'(dtack_n), 1);
    check("R11 reset rdata", int'(rdata), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();

    // strap classification; status = {cfg, valid, code}
    set_mode(0);
    read_cfg(16'h0000, 8'h04, "R1 ground strap status");
    // R8: base is 0 and unplaced, so blocks 0 and 1 must stay silent
    bus_cycle(24'h000100, 1'b1, 8'h00, 8'h00, S_NONE, -1, "R8 rom block before config");
    bus_cycle(24'h010000, 1'b1, 8'h00, 8'h00, S_NONE, -1, "R8 ram block before config");
    set_mode(3);
    read_cfg(16'h0000, 8'h05, "R2 inverted clock strap status");
    set_mode(2);
    read_cfg(16'h0000, 8'h06, "R3 true clock strap status");
    set_mode(4);
    read_cfg(16'h0000, 8'h00, "R5 unmatched strap status");
    set_mode(1);
    read_cfg(16'h0000, 8'h07, "R4 vcc strap status");

    // R6 slave on other config offsets, data 0
    read_cfg(16'h0010, 8'h00, "R6 R9 unused config offset");

    // place the card; changing data mid-strobe must be ignored
    bus_cycle(24'hE80048, 1'b0, 8'h20, 8'h55, S_SLAVE, -1, "R9 R12 base write");
    read_cfg(16'h0002, 8'h20, "R9 R12 base readback");
    read_cfg(16'h0000, 8'h0F, "R9 status after config");

    // 2 MB window: rom at 0x20, ram 0x21..0x40
    bus_cycle(24'h201234, 1'b1, 8'h00, 8'h00, S_ROM,  -1, "R10 R7 rom block");
    bus_cycle(24'h210000, 1'b0, 8'h00, 8'h00, S_RAM,  -1, "R10 R7 first ram block");
    bus_cycle(24'h40FFFE, 1'b1, 8'h00, 8'h00, S_RAM,  -1, "R10 last 2M ram block");
    bus_cycle(24'h410000, 1'b1, 8'h00, 8'h00, S_NONE, -1, "R10 past 2M window");
    bus_cycle(24'h1F0000, 1'b1, 8'h00, 8'h00, S_NONE, -1, "R10 below base");

    // 1 MB window: ram 0x21..0x30
    set_mode(2);
    bus_cycle(24'h300000, 1'b1, 8'h00, 8'h00, S_RAM,  -1, "R10 R3 last 1M ram block");
    bus_cycle(24'h310000, 1'b1, 8'h00, 8'h00, S_NONE, -1, "R10 R3 past 1M window");

    // R11 reset clears placement
    do_reset();
    read_cfg(16'h0000, 8'h00, "R11 status after reset");
    read_cfg(16'h0002, 8'h00, "R11 base after reset");
    bus_cycle(24'h200000, 1'b1, 8'h00, 8'h00, S_NONE, -1, "R11 R8 rom block after reset");

    repeat (5) @(negedge clk);
    check("scoreboard drained", sbq.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule